// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block collects interrupt requests for a single processor and presents them as one interrupt line. There are 24 sources. Sources 0 to 4 come from external pins, which pass through a synchronizer first. Sources 5 to 23 are single-bit requests that are already synchronous to the clock. Timer events use sources 16 to 19, and other on-chip units use sources 20 to 23.

Each source has a configuration word and a destination word, both set through a simple register port. The configuration word holds:
- a mask bit,
- a read-only activity flag,
- a polarity bit and a sense bit,
- a 4-bit priority,
- an 8-bit vector.

The controller raises its interrupt output while some source qualifies. A source qualifies when it is pending, unmasked and routed, and its priority is above both the task-priority register and the most urgent level already in service.

Software reads an acknowledge location to learn the vector of the winning source, and that read moves the source into service. Any write to an end-of-interrupt location retires the most urgent in-service source. This lets urgent sources preempt less urgent handlers, which gives nested servicing. Writing a self-clearing bit in the global word returns the whole controller to its masked, idle state.

Top module: `prio_intc`

## Requirements
- R1: After reset:
  - irq_o is low.
  - Every source configuration word (word address 0x40+2i) reads 0x8000_0000.
  - Every destination word (0x41+2i) reads 0.
  - The task-priority word (0x01) reads 0.
  - A read of the acknowledge word (0x02) returns 0xFF.
- R2: A source whose mask bit (bit 31 of its configuration word) is 1 never drives irq_o and never wins an acknowledge. An edge that arrives while the source is masked is not recorded.
- R3: A source whose destination bit 0 is 0 is never delivered.
- R4: The priority field is bits 19:16, and a larger value is more urgent. Among equally urgent sources, the lower index wins. A priority of 0 never produces an interrupt.
- R5: A source is delivered only while its priority is strictly above the value in bits 3:0 of the task-priority word (0x01).
- R6: A read of the acknowledge word returns the winner's vector field (bits 7:0), zero-extended. It returns 0xFF when no source qualifies. All read data is valid on the cycle after the request.
- R7: An acknowledge puts the winner in service and clears its pending state if it is edge-sensitive. The activity bit (bit 30) reads 1 while a source is pending or in service.
- R8: A source is not delivered unless its priority is above the most urgent in-service priority. Any write to word 0x03 retires the most urgent in-service source, with ties going to the lower index.
- R9: The sense bit selects level (1) or edge (0) detection, at bit 22. The polarity bit selects active-high or rising (1) versus active-low or falling (0), at bit 23. Pins 0 to 4 pass a two-stage synchronizer.
- R10: Writing 1 to bit 31 of the global word (0x00) starts an internal reset.
  - Bit 31 reads 1 for RST_CYC cycles and then reads 0.
  - Every mask bit becomes 1.
  - All pending and in-service state is cleared.
- R11: irq_o is a registered output. It is high in the cycle after a qualifying source exists.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_en | input | 1 | Register access strobe, one access per cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read |
| ext_pin_i | input | NUM_EXT | Asynchronous external request pins (sources 0..NUM_EXT-1) |
| int_req_i | input | NUM_SRC-NUM_EXT | Synchronous internal requests (sources NUM_EXT and up) |
| irq_o | output | 1 | Interrupt request to the processor |

## Verification
On every cycle, the embedded properties check the following:
- The winning source is always unmasked and above both the task priority and the in-service level.
- An acknowledge with no winner returns 0xFF.
- An acknowledge always sets the winner's in-service bit, and an end-of-interrupt always clears the bit it selected.
- The internal reset empties the in-service set.

Only the bench scenarios can show the remaining behaviour:
- which source wins on ties and on priority 0,
- that edges are consumed and that edges arriving while masked are ignored,
- that polarity and sense select the right transitions,
- the correct nesting order across several end-of-interrupt writes.

// File: rtl/prio_intc_pkg.sv
package prio_intc_pkg;
  localparam int DATA_W = 32;
  localparam int PRIO_W = 4;
  localparam int VEC_W  = 8;

  // configuration word bit positions (decoded by software)
  localparam int B_MASK  = 31;
  localparam int B_ACT   = 30;
  localparam int B_POL   = 23;
  localparam int B_SENSE = 22;
  localparam int B_PRIO  = 16;

  localparam logic [VEC_W-1:0] SPURIOUS_VEC = 8'hFF;

  // word addresses
  localparam int A_GCR      = 0;
  localparam int A_CTP      = 1;
  localparam int A_ACK      = 2;
  localparam int A_EOI      = 3;
  localparam int A_SRC_BASE = 64;

  typedef struct packed {
    logic              mask;
    logic              pol;
    logic              sense;
    logic [PRIO_W-1:0] prio;
    logic [VEC_W-1:0]  vec;
  } src_cfg_t;

  function automatic logic [DATA_W-1:0] pack_cfg(src_cfg_t c, logic active);
    logic [DATA_W-1:0] w;
    w = '0;
    w[B_MASK]              = c.mask;
    w[B_ACT]               = active;
    w[B_POL]               = c.pol;
    w[B_SENSE]             = c.sense;
    w[B_PRIO +: PRIO_W]    = c.prio;
    w[VEC_W-1:0]           = c.vec;
    return w;
  endfunction
endpackage

// File: rtl/prio_intc_src.sv
module prio_intc_src #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic clr_i,
  input  logic mask_i,
  input  logic pol_i,
  input  logic sense_i,
  input  logic ack_i,
  input  logic raw_i,
  output logic pend_o
);
  logic s_in;
  logic act;
  logic act_q;
  logic lvl_q;
  logic edg_q;

  if (SYNC_STAGES > 0) begin : g_sync
    logic [SYNC_STAGES-1:0] sh_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        sh_q <= '0;
      end else begin
        for (int k = SYNC_STAGES - 1; k > 0; k--) sh_q[k] <= sh_q[k-1];
        sh_q[0] <= raw_i;
      end
    end
    assign s_in = sh_q[SYNC_STAGES-1];
  end else begin : g_direct
    assign s_in = raw_i;
  end

  assign act = pol_i ? s_in : ~s_in;

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q <= 1'b0;
      lvl_q <= 1'b0;
      edg_q <= 1'b0;
    end else begin
      act_q <= act;
      lvl_q <= act & ~clr_i;
      if (clr_i)                          edg_q <= 1'b0;
      else if (act && !act_q && !mask_i)  edg_q <= 1'b1;
      else if (ack_i)                     edg_q <= 1'b0;
    end
  end

  assign pend_o = sense_i ? lvl_q : edg_q;

  // R9: an unmasked qualifying transition is held as pending
  a_r9_edge_latched: assert property (@(posedge clk) disable iff (rst)
    (!clr_i && !mask_i && act && !act_q) |=> edg_q);
  // R10: internal reset empties both pending flavours
  a_r10_src_cleared: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> (!edg_q && !lvl_q));
endmodule

// File: rtl/prio_intc_arb.sv
module prio_intc_arb #(
  parameter int N  = 24,
  parameter int PW = 4
) (
  input  logic [N-1:0]    req_i,
  input  logic [N*PW-1:0] prio_i,
  output logic            any_o,
  output logic [$clog2(N)-1:0] idx_o,
  output logic [PW-1:0]   prio_o
);
  localparam int IW = $clog2(N);

  // scan from the top index down; ">=" lets a lower index take a tie
  always_comb begin
    any_o  = 1'b0;
    idx_o  = '0;
    prio_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i] && (!any_o || prio_i[i*PW +: PW] >= prio_o)) begin
        any_o  = 1'b1;
        idx_o  = IW'(i);
        prio_o = prio_i[i*PW +: PW];
      end
    end
    a_r4_pick_requested: assert (!any_o || req_i[idx_o]);
    a_r4_idle_when_none: assert (any_o || (req_i == '0));
  end
endmodule

// File: rtl/prio_intc.sv
module prio_intc
  import prio_intc_pkg::*;
#(
  parameter int NUM_SRC     = 24,
  parameter int NUM_EXT     = 5,
  parameter int SYNC_STAGES = 2,
  parameter int RST_CYC     = 8,
  parameter int ADDR_W      = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       bus_en,
  input  logic                       bus_we,
  input  logic [ADDR_W-1:0]          bus_addr,
  input  logic [DATA_W-1:0]          bus_wdata,
  output logic [DATA_W-1:0]          bus_rdata,
  input  logic [NUM_EXT-1:0]         ext_pin_i,
  input  logic [NUM_SRC-NUM_EXT-1:0] int_req_i,
  output logic                       irq_o
);
  localparam int IDX_W = $clog2(NUM_SRC);
  localparam int CNT_W = $clog2(RST_CYC + 1);

  src_cfg_t              cfg_q [NUM_SRC];
  logic [NUM_SRC-1:0]    dest_q;
  logic [NUM_SRC-1:0]    isr_q;
  logic [NUM_SRC-1:0]    pend;
  logic [NUM_SRC-1:0]    qual;
  logic [NUM_SRC-1:0]    raw_all;
  logic [NUM_SRC*PRIO_W-1:0] prio_flat;
  logic [PRIO_W-1:0]     ctp_q;
  logic                  busy_q;
  logic [CNT_W-1:0]      cnt_q;

  logic                  win_any, isr_any;
  logic [IDX_W-1:0]      win_idx, isr_idx;
  logic [PRIO_W-1:0]     win_prio, isr_prio;

  logic                  wr, rd, gcr_wr, ctp_wr, eoi_wr, ack_rd, ack_hit;
  logic                  in_src;
  logic [ADDR_W-1:0]     src_off;
  logic [IDX_W-1:0]      sidx;
  logic [DATA_W-1:0]     rd_mux;
  logic                  unused_wd;

  // ---------------- address decode ----------------
  assign wr      = bus_en &  bus_we;
  assign rd      = bus_en & ~bus_we;
  assign src_off = bus_addr - ADDR_W'(A_SRC_BASE);
  assign in_src  = (bus_addr >= ADDR_W'(A_SRC_BASE)) && (src_off < ADDR_W'(2 * NUM_SRC));
  assign sidx    = src_off[IDX_W:1];
  assign gcr_wr  = wr && (bus_addr == ADDR_W'(A_GCR)) && bus_wdata[DATA_W-1];
  assign ctp_wr  = wr && (bus_addr == ADDR_W'(A_CTP));
  assign eoi_wr  = wr && (bus_addr == ADDR_W'(A_EOI));
  assign ack_rd  = rd && (bus_addr == ADDR_W'(A_ACK));
  assign ack_hit = ack_rd && win_any && !busy_q;
  assign unused_wd = ^{bus_wdata[30:24], bus_wdata[21:20], bus_wdata[15:8]};

  assign raw_all = {int_req_i, ext_pin_i};

  // ---------------- per-source detection and qualification ----------------
  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    prio_intc_src #(
      .SYNC_STAGES(g < NUM_EXT ? SYNC_STAGES : 0)
    ) u_src (
      .clk     (clk),
      .rst     (rst),
      .clr_i   (busy_q),
      .mask_i  (cfg_q[g].mask),
      .pol_i   (cfg_q[g].pol),
      .sense_i (cfg_q[g].sense),
      .ack_i   (ack_hit && (win_idx == IDX_W'(g))),
      .raw_i   (raw_all[g]),
      .pend_o  (pend[g])
    );
    assign prio_flat[g*PRIO_W +: PRIO_W] = cfg_q[g].prio;
    assign qual[g] = pend[g] && !cfg_q[g].mask && dest_q[g] &&
                     (cfg_q[g].prio != '0) && (cfg_q[g].prio > ctp_q) &&
                     (cfg_q[g].prio > isr_prio);
  end

  // ---------------- arbitration ----------------
  prio_intc_arb #(.N(NUM_SRC), .PW(PRIO_W)) u_win_arb (
    .req_i  (qual),
    .prio_i (prio_flat),
    .any_o  (win_any),
    .idx_o  (win_idx),
    .prio_o (win_prio)
  );

  prio_intc_arb #(.N(NUM_SRC), .PW(PRIO_W)) u_isr_arb (
    .req_i  (isr_q),
    .prio_i (prio_flat),
    .any_o  (isr_any),
    .idx_o  (isr_idx),
    .prio_o (isr_prio)
  );

  // ---------------- configuration registers ----------------
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_SRC; i++) cfg_q[i] <= '{mask: 1'b1, default: '0};
      dest_q <= '0;
      ctp_q  <= '0;
    end else begin
      if (ctp_wr) ctp_q <= bus_wdata[PRIO_W-1:0];
      if (wr && in_src) begin
        if (src_off[0]) begin
          dest_q[sidx] <= bus_wdata[0];
        end else begin
          cfg_q[sidx] <= '{mask:  bus_wdata[B_MASK],
                           pol:   bus_wdata[B_POL],
                           sense: bus_wdata[B_SENSE],
                           prio:  bus_wdata[B_PRIO +: PRIO_W],
                           vec:   bus_wdata[VEC_W-1:0]};
        end
      end
      if (busy_q) begin
        for (int i = 0; i < NUM_SRC; i++) cfg_q[i].mask <= 1'b1;
      end
    end
  end

  // ---------------- self-clearing global reset ----------------
  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (busy_q) begin
      if (cnt_q == '0) busy_q <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end else if (gcr_wr) begin
      busy_q <= 1'b1;
      cnt_q  <= CNT_W'(RST_CYC - 1);
    end
  end

  // ---------------- in-service set ----------------
  always_ff @(posedge clk) begin
    if (rst || busy_q) begin
      isr_q <= '0;
    end else begin
      if (ack_hit)            isr_q[win_idx] <= 1'b1;
      if (eoi_wr && isr_any)  isr_q[isr_idx] <= 1'b0;
    end
  end

  // ---------------- read path and interrupt output ----------------
  always_comb begin
    rd_mux = '0;
    if (in_src) begin
      if (src_off[0]) rd_mux = DATA_W'(dest_q[sidx]);
      else            rd_mux = pack_cfg(cfg_q[sidx], pend[sidx] | isr_q[sidx]);
    end else begin
      case (bus_addr)
        ADDR_W'(A_GCR): rd_mux[DATA_W-1] = busy_q;
        ADDR_W'(A_CTP): rd_mux[PRIO_W-1:0] = ctp_q;
        ADDR_W'(A_ACK): rd_mux[VEC_W-1:0] = (win_any && !busy_q) ? cfg_q[win_idx].vec
                                                                 : SPURIOUS_VEC;
        default:        rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      irq_o     <= 1'b0;
    end else begin
      if (rd) bus_rdata <= rd_mux;
      irq_o <= win_any && !busy_q;
    end
  end

  // ---------------- properties ----------------
  // R2: the delivered source is never masked
  a_r2_winner_unmasked: assert property (@(posedge clk) disable iff (rst)
    win_any |-> !cfg_q[win_idx].mask);
  // R5: the delivered source beats the task priority
  a_r5_above_task: assert property (@(posedge clk) disable iff (rst)
    win_any |-> (win_prio > ctp_q));
  // R8: the delivered source beats the in-service level
  a_r8_above_service: assert property (@(posedge clk) disable iff (rst)
    win_any |-> (win_prio > isr_prio));
  // R6: empty acknowledge returns the spurious code
  a_r6_spurious_code: assert property (@(posedge clk) disable iff (rst)
    (ack_rd && !ack_hit) |=> (bus_rdata == DATA_W'(SPURIOUS_VEC)));
  // R7: acknowledge marks the winner in service
  a_r7_ack_in_service: assert property (@(posedge clk) disable iff (rst)
    ack_hit |=> isr_q[$past(win_idx)]);
  // R8: end-of-interrupt retires the chosen in-service bit
  a_r8_eoi_retires: assert property (@(posedge clk) disable iff (rst)
    (eoi_wr && isr_any && !busy_q) |=> !isr_q[$past(isr_idx)]);
  // R10: a started reset reads busy and empties the in-service set
  a_r10_busy_starts: assert property (@(posedge clk) disable iff (rst)
    (gcr_wr && !busy_q) |=> busy_q);
  a_r10_service_cleared: assert property (@(posedge clk) disable iff (rst)
    busy_q |=> (isr_q == '0));
  // R11: output reflects the previous cycle's qualification
  a_r11_irq_registered: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> $past(win_any));
endmodule

// File: tb/prio_intc_tb_top.sv
`timescale 1ns/1ps
module prio_intc_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        en = 1'b0, we = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wd = '0;
  logic [31:0] rdata;
  logic [4:0]  ext = '0;
  logic [18:0] intr = '0;
  logic        irq;
  int          n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  prio_intc dut_i (
    .clk(clk), .rst(rst), .bus_en(en), .bus_we(we), .bus_addr(addr),
    .bus_wdata(wd), .bus_rdata(rdata), .ext_pin_i(ext), .int_req_i(intr),
    .irq_o(irq)
  );

  function automatic logic [31:0] mk(bit m, bit p, bit s, int pr, int v);
    return {m, 1'b0, 6'b0, p, s, 2'b0, 4'(pr), 8'b0, 8'(v)};
  endfunction

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk); en = 1; we = 1; addr = a; wd = d;
    @(negedge clk); en = 0; we = 0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk); en = 1; we = 0; addr = a;
    @(negedge clk); en = 0; d = rdata;
  endtask

  task automatic cfg(int i, logic [31:0] d);  wr(8'(64 + 2*i), d);     endtask
  task automatic dst(int i, logic [31:0] d);  wr(8'(65 + 2*i), d);     endtask
  task automatic eoi();                       wr(8'd3, 32'h0);         endtask
  task automatic ack(output logic [31:0] d);  rd(8'd2, d);             endtask

  task automatic set_src(int i, bit v);
    @(negedge clk);
    if (i < 5) ext[i] = v; else intr[i-5] = v;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (4) @(posedge clk);
    @(negedge clk) rst = 0;

    // ---- R1: reset state
    check("R1 irq after reset", 32'(irq), 0);
    for (int i = 0; i < 24; i++) begin
      rd(8'(64 + 2*i), d); check("R1 cfg reset", d, 32'h8000_0000);
      rd(8'(65 + 2*i), d); check("R1 dest reset", d, 0);
    end
    rd(8'd1, d); check("R1 task prio reset", d, 0);
    ack(d);      check("R1 ack empty", d, 32'hFF);

    // ---- per-source sweep, level active-high (R6 R7 R8 R11)
    for (int i = 0; i < 24; i++) begin
      cfg(i, mk(0, 1, 1, (i % 15) + 1, i + 32));
      dst(i, 1);
      set_src(i, 1);
      wait_n(6);
      check("R11 irq raised", 32'(irq), 1);
      rd(8'(64 + 2*i), d);
      check("R7 activity while pending", d, mk(0, 1, 1, (i % 15) + 1, i + 32) | 32'h4000_0000);
      ack(d); check("R6 ack vector", d, 32'(i + 32));
      wait_n(3);
      check("R8 own level blocks", 32'(irq), 0);
      set_src(i, 0);
      wait_n(6);
      eoi();
      wait_n(3);
      check("R8 idle after eoi", 32'(irq), 0);
      ack(d); check("R6 spurious after retire", d, 32'hFF);
      cfg(i, mk(1, 1, 1, (i % 15) + 1, i + 32));
    end

    // ---- R2 R3 R4: mask, destination, priority zero
    cfg(7, mk(1, 1, 1, 5, 7)); dst(7, 1); set_src(7, 1);
    wait_n(4);
    check("R2 masked no irq", 32'(irq), 0);
    ack(d); check("R2 masked no ack", d, 32'hFF);
    dst(7, 0); cfg(7, mk(0, 1, 1, 5, 7)); wait_n(4);
    check("R3 unrouted no irq", 32'(irq), 0);
    ack(d); check("R3 unrouted no ack", d, 32'hFF);
    dst(7, 1); cfg(7, mk(0, 1, 1, 0, 7)); wait_n(4);
    check("R4 prio zero no irq", 32'(irq), 0);
    cfg(7, mk(0, 1, 1, 5, 7)); wait_n(4);
    check("R2 unmasked irq", 32'(irq), 1);
    ack(d); check("R2 unmasked ack", d, 7);
    set_src(7, 0); wait_n(3); eoi(); cfg(7, mk(1, 1, 1, 5, 7));

    // R2: an edge seen while masked is dropped
    cfg(8, mk(1, 1, 0, 5, 8)); dst(8, 1);
    set_src(8, 1); wait_n(4);
    cfg(8, mk(0, 1, 0, 5, 8)); wait_n(3);
    check("R2 masked edge dropped irq", 32'(irq), 0);
    ack(d); check("R2 masked edge dropped ack", d, 32'hFF);
    set_src(8, 0); cfg(8, mk(1, 1, 0, 5, 8));

    // ---- R4: full priority pair sweep, source 2 vs source 20
    dst(2, 1); dst(20, 1);
    set_src(2, 1); set_src(20, 1);
    for (int pa = 0; pa < 16; pa++) begin
      for (int pb = 0; pb < 16; pb++) begin
        logic [31:0] exp;
        cfg(2, mk(0, 1, 1, pa, 8'h42));
        cfg(20, mk(0, 1, 1, pb, 8'h99));
        wait_n(3);
        check("R4 irq for pair", 32'(irq), 32'((pa != 0) || (pb != 0)));
        if (pa == 0 && pb == 0) exp = 32'hFF;
        else if (pa >= pb)      exp = 32'h42;
        else                    exp = 32'h99;
        ack(d); check("R4 pair winner", d, exp);
        if (exp != 32'hFF) eoi();
      end
    end
    cfg(2, mk(1, 1, 1, 1, 8'h42)); cfg(20, mk(1, 1, 1, 1, 8'h99));
    set_src(2, 0); set_src(20, 0);
    wait_n(6);

    // ---- R5: task priority sweep
    cfg(20, mk(0, 1, 1, 6, 8'h55)); set_src(20, 1);
    for (int c = 0; c < 16; c++) begin
      wr(8'd1, 32'(c));
      wait_n(3);
      check("R5 irq vs task prio", 32'(irq), 32'(6 > c));
      rd(8'd1, d); check("R5 task prio readback", d, 32'(c));
    end
    wr(8'd1, 0);
    cfg(20, mk(1, 1, 1, 6, 8'h55)); set_src(20, 0); wait_n(3);

    // ---- R8: nesting and retire order
    dst(21, 1); dst(22, 1);
    cfg(20, mk(0, 1, 1, 4, 8'h14));
    cfg(21, mk(0, 1, 1, 3, 8'h15));
    cfg(22, mk(0, 1, 1, 9, 8'h16));
    set_src(20, 1); wait_n(3);
    ack(d); check("R8 first level", d, 8'h14);
    set_src(21, 1); wait_n(4);
    check("R8 lower blocked by service", 32'(irq), 0);
    set_src(22, 1); wait_n(4);
    check("R8 higher nests", 32'(irq), 1);
    ack(d); check("R8 nested vector", d, 8'h16);
    eoi(); wait_n(3);
    check("R8 eoi retired top first", 32'(irq), 1);
    ack(d); check("R8 redelivered top", d, 8'h16);
    set_src(22, 0); wait_n(3); eoi(); wait_n(3);
    check("R8 still blocked by outer", 32'(irq), 0);
    eoi(); wait_n(3);
    check("R8 outer retired", 32'(irq), 1);
    ack(d); check("R8 outer redelivered", d, 8'h14);
    set_src(20, 0); set_src(21, 0); wait_n(3); eoi();
    cfg(20, mk(1, 1, 1, 4, 8'h14)); cfg(21, mk(1, 1, 1, 3, 8'h15));
    cfg(22, mk(1, 1, 1, 9, 8'h16));

    // ---- R9 R7: edge and polarity on a synchronized pin
    cfg(1, mk(0, 1, 0, 7, 8'h31)); dst(1, 1);
    set_src(1, 1); wait_n(6);
    check("R9 rising edge irq", 32'(irq), 1);
    ack(d); check("R9 rising edge vector", d, 8'h31);
    rd(8'(66), d); check("R7 activity in service", d, mk(0, 1, 0, 7, 8'h31) | 32'h4000_0000);
    eoi(); wait_n(3);
    check("R7 edge consumed", 32'(irq), 0);
    ack(d); check("R7 edge consumed ack", d, 32'hFF);
    rd(8'(66), d); check("R7 activity clear", d, mk(0, 1, 0, 7, 8'h31));
    cfg(1, mk(0, 0, 0, 7, 8'h31)); wait_n(3);
    check("R9 no edge on rise with falling polarity", 32'(irq), 0);
    set_src(1, 0); wait_n(6);
    check("R9 falling edge irq", 32'(irq), 1);
    ack(d); check("R9 falling edge vector", d, 8'h31);
    eoi(); cfg(1, mk(1, 0, 0, 7, 8'h31));
    cfg(3, mk(0, 0, 1, 7, 8'h33)); dst(3, 1); wait_n(6);
    check("R9 active-low level irq", 32'(irq), 1);
    ack(d); check("R9 active-low vector", d, 8'h33);
    set_src(3, 1); wait_n(6); eoi(); wait_n(3);
    check("R9 level released", 32'(irq), 0);
    cfg(3, mk(1, 0, 1, 7, 8'h33)); set_src(3, 0);

    // ---- R10: global reset
    cfg(20, mk(0, 1, 1, 6, 8'h14)); cfg(21, mk(0, 1, 1, 8, 8'h15));
    set_src(20, 1); wait_n(3);
    ack(d); check("R10 setup ack", d, 8'h14);
    set_src(21, 1); wait_n(3);
    check("R10 setup irq", 32'(irq), 1);
    wr(8'd0, 32'h8000_0000);
    rd(8'd0, d); check("R10 busy reads one", d, 32'h8000_0000);
    wait_n(12);
    rd(8'd0, d); check("R10 busy self-clears", d, 0);
    check("R10 irq after reset", 32'(irq), 0);
    rd(8'(64 + 42), d); check("R10 mask set", d, mk(1, 1, 1, 8, 8'h15) | 32'h4000_0000);
    ack(d); check("R10 no winner", d, 32'hFF);
    cfg(20, mk(0, 1, 1, 6, 8'h14)); wait_n(3);
    check("R10 service cleared", 32'(irq), 1);
    ack(d); check("R10 redelivered", d, 8'h14);
    set_src(20, 0); set_src(21, 0); wait_n(3); eoi();

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule